// File: doc/BRIEF.md
# Reference Frequency Monitor and Failover Controller

This block sits next to a clock-multiplying loop and decides which of two reference clocks, a primary and a backup, feeds it. It counts the rising edges of each reference over a fixed gate of cycles of a stable local timebase. It then places each count into one of six frequency bands, where each band is twice the frequency of the band below it. A reference counts as usable once two measurements in a row land in the same band. The block reports a feedback divide ratio for the selected reference, so the loop output frequency does not change when the two references sit in different bands.

The primary is preferred. When it becomes unusable and the backup is usable, a hold request freezes the loop for a fixed number of cycles before the input selection changes. The same sequence runs in reverse when the primary recovers. The active-low lock flag goes low only while the loop runs from a usable primary. The primary must also have been usable for a full acquisition period, and its latest count must sit inside a narrow window around its band's nominal value. A two-digit, three-level band select can force one band or leave detection automatic.

Top module: `refmon_failover`

## Requirements
- R1: After reset, `use_bak` is 0, `hold_req` is 0, `lock_n` is 1 and `fb_div` is 32. All measurement state and validity state is cleared.
- R2: Band k (k = 0..5) has a nominal count of BAND0_NOM·2^k edges per GATE_CYC timebase cycles and accepts counts within ±nominal/BAND_TOL_DIV. A count of zero, or a count outside every band, makes that reference invalid at once.
- R3: A reference becomes valid only after two consecutive measurements that fall in the same accepted band.
- R4: `fb_div` is 32 >> b, where b is the latched band of the selected reference. This gives 32, 16, 8, 4, 2 and 1 for bands 0 to 5.
- R5: When the primary is on, the primary is invalid and the backup is valid, `hold_req` rises for HOLD_CYC cycles while `use_bak` stays 0. Then `use_bak` becomes 1 on the same edge that `hold_req` falls.
- R6: When the backup is on and the primary becomes valid, the same hold sequence runs and `use_bak` returns to 0.
- R7: `lock_n` is 0 only while the primary is selected, not in a hold and valid. It is 1 while the backup is selected.
- R8: `lock_n` goes low no sooner than ACQ_CYC cycles after the primary becomes selected and valid. Any loss of validity restarts that period.
- R9: `lock_n` is 1 whenever the latest primary count lies outside nominal ± nominal/LOCK_TOL_DIV of its band, even though the count is still inside the band.
- R10: `band_sel` holds two digits, [3:2] and [1:0], with code 0 = low, 1 = mid, 2 = high and 3 read as mid. The codes map as follows: (high,high) gives band 0, (high,low) band 1, (mid,high) band 2, (mid,low) band 3, (low,high) band 4 and (low,low) band 5. (mid,mid) selects automatic detection. The reserved codes (high,mid) and (low,mid) also act as automatic detection.
- R11: In a manual band, a reference whose count falls in any other band is invalid.
- R12: When neither reference is valid, the primary stays selected, no hold is requested and `fb_div` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stable local timebase |
| rst | input | 1 | Synchronous reset, active high |
| pri_clk | input | 1 | Primary reference clock (asynchronous) |
| bak_clk | input | 1 | Backup reference clock (asynchronous) |
| band_sel | input | 4 | Two three-level digits: manual band or automatic detection |
| use_bak | output | 1 | 1 when the backup reference drives the loop |
| fb_div | output | 6 | Feedback divide ratio for the selected reference |
| hold_req | output | 1 | Loop must hold its frequency (changeover in progress) |
| lock_n | output | 1 | Active-low lock to a valid, in-window primary |

## Verification
A wrong latched band shows at the ports as a wrong `fb_div` value as soon as that reference is selected, at most one hold window after a changeover. A validity flag that is set or cleared at the wrong time shows up one gate too early or too late in the rise of `hold_req`. It shows up the same way in the toggling of `use_bak`, and the scenarios that stop, restart and detune a reference expose it within two or three gates. An acquisition or window error shows only on `lock_n`, either as an early fall after a return to the primary or as lock that persists while the primary runs out of window.

// File: rtl/refmon_pkg.sv
`timescale 1ns/1ps
package refmon_pkg;
  localparam int NBANDS = 6;
  localparam int BAND_W = 3;
  localparam int DIV_W  = 6;

  typedef logic [BAND_W-1:0] band_t;

  typedef enum logic [1:0] {
    FO_PRI    = 2'd0,
    FO_TO_BAK = 2'd1,
    FO_BAK    = 2'd2,
    FO_TO_PRI = 2'd3
  } fo_state_e;

  typedef struct packed {
    logic  hit;
    band_t band;
  } band_hit_t;

  typedef struct packed {
    logic  manual;
    band_t band;
  } band_req_t;

  // Place an edge count into the doubling band ladder.
  function automatic band_hit_t classify_count(input int cnt, input int nom0, input int tol_div);
    band_hit_t r;
    r.hit  = 1'b0;
    r.band = '0;
    for (int k = 0; k < NBANDS; k++) begin
      int nom;
      int tol;
      nom = nom0 << k;
      tol = nom / tol_div;
      if (!r.hit && cnt != 0 && cnt >= nom - tol && cnt <= nom + tol) begin
        r.hit  = 1'b1;
        r.band = band_t'(k);
      end
    end
    return r;
  endfunction

  // Ratio relative to the top band: lowest band needs the largest ratio.
  function automatic logic [DIV_W-1:0] divide_ratio(input band_t b);
    logic [DIV_W-1:0] top;
    top = 6'd32;
    return top >> b;
  endfunction

  // Narrow window around the nominal count of a band.
  function automatic logic in_lock_window(input int cnt, input band_t b, input int nom0, input int lock_div);
    int nom;
    int tol;
    nom = nom0 << b;
    tol = nom / lock_div;
    return (cnt >= nom - tol) && (cnt <= nom + tol);
  endfunction

  // Two three-level digits; code 3 reads as mid.
  function automatic band_req_t decode_band_sel(input logic [3:0] sel);
    logic [1:0] a;
    logic [1:0] b;
    band_req_t  r;
    a = (sel[3:2] == 2'd3) ? 2'd1 : sel[3:2];
    b = (sel[1:0] == 2'd3) ? 2'd1 : sel[1:0];
    r.manual = 1'b1;
    case ({a, b})
      4'b1010: r.band = 3'd0;
      4'b1000: r.band = 3'd1;
      4'b0110: r.band = 3'd2;
      4'b0100: r.band = 3'd3;
      4'b0010: r.band = 3'd4;
      4'b0000: r.band = 3'd5;
      default: begin
        r.manual = 1'b0;
        r.band   = 3'd0;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ref_edge_counter.sv
`timescale 1ns/1ps
module ref_edge_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_clk,
  input  logic             gate_end,
  output logic [CNT_W-1:0] meas,
  output logic             meas_done
);
  logic [2:0]       sync_q;
  logic             edge_seen;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;

  assign edge_seen = sync_q[1] & ~sync_q[2];
  assign cnt_nxt   = cnt + {{(CNT_W-1){1'b0}}, edge_seen};

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '0;
      cnt       <= '0;
      meas      <= '0;
      meas_done <= 1'b0;
    end else begin
      sync_q    <= {sync_q[1:0], ref_clk};
      meas_done <= gate_end;
      if (gate_end) begin
        meas <= cnt_nxt;
        cnt  <= '0;
      end else begin
        cnt  <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/ref_qualifier.sv
`timescale 1ns/1ps
module ref_qualifier
  import refmon_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int BAND0_NOM    = 16,
  parameter int BAND_TOL_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] meas,
  input  logic             meas_done,
  input  logic             manual,
  input  band_t            man_band,
  output logic             valid,
  output band_t            band
);
  band_hit_t res;
  logic      res_ok;
  logic      streak;
  band_t     cand;

  assign res    = classify_count(int'(meas), BAND0_NOM, BAND_TOL_DIV);
  assign res_ok = res.hit && (!manual || res.band == man_band);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      band   <= '0;
      streak <= 1'b0;
      cand   <= '0;
    end else if (meas_done) begin
      if (!res_ok) begin
        valid  <= 1'b0;
        streak <= 1'b0;
      end else if (streak && cand == res.band) begin
        valid <= 1'b1;
        band  <= res.band;
      end else begin
        streak <= 1'b1;
        cand   <= res.band;
        valid  <= 1'b0;
      end
    end
  end

  // R3
  debounce_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> ($past(meas_done) && $past(streak)));

  // R2
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (meas_done && meas == '0) |=> !valid);
endmodule

// File: rtl/failover_ctrl.sv
`timescale 1ns/1ps
module failover_ctrl
  import refmon_pkg::*;
#(
  parameter int HOLD_CYC = 16,
  parameter int ACQ_CYC  = 8192
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pri_valid,
  input  logic             bak_valid,
  input  band_t            pri_band,
  input  band_t            bak_band,
  input  logic             pri_in_win,
  output logic             use_bak,
  output logic             hold_req,
  output logic             lock_n,
  output logic [DIV_W-1:0] fb_div
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam int ACQ_W  = $clog2(ACQ_CYC + 1);

  fo_state_e         state;
  logic [HOLD_W-1:0] hold_cnt;
  logic [ACQ_W-1:0]  acq_cnt;
  logic              hold_last;
  logic              acq_done;
  logic              lock_cond;

  assign hold_last = hold_cnt == HOLD_W'(HOLD_CYC - 1);
  assign acq_done  = acq_cnt == ACQ_W'(ACQ_CYC);
  assign hold_req  = (state == FO_TO_BAK) || (state == FO_TO_PRI);
  assign lock_cond = (state == FO_PRI) && pri_valid && acq_done && pri_in_win;
  assign fb_div    = divide_ratio(use_bak ? bak_band : pri_band);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= FO_PRI;
      use_bak  <= 1'b0;
      hold_cnt <= '0;
      acq_cnt  <= '0;
      lock_n   <= 1'b1;
    end else begin
      case (state)
        FO_PRI: begin
          hold_cnt <= '0;
          if (!pri_valid && bak_valid) state <= FO_TO_BAK;
        end
        FO_TO_BAK: begin
          if (hold_last) begin
            state    <= FO_BAK;
            use_bak  <= 1'b1;
            hold_cnt <= '0;
          end else begin
            hold_cnt <= hold_cnt + HOLD_W'(1);
          end
        end
        FO_BAK: begin
          hold_cnt <= '0;
          if (pri_valid) state <= FO_TO_PRI;
        end
        FO_TO_PRI: begin
          if (hold_last) begin
            state    <= FO_PRI;
            use_bak  <= 1'b0;
            hold_cnt <= '0;
          end else begin
            hold_cnt <= hold_cnt + HOLD_W'(1);
          end
        end
        default: state <= FO_PRI;
      endcase

      if (state == FO_PRI && pri_valid) begin
        if (!acq_done) acq_cnt <= acq_cnt + ACQ_W'(1);
      end else begin
        acq_cnt <= '0;
      end

      lock_n <= !lock_cond;
    end
  end

  // R5
  hold_before_switch_chk: assert property (@(posedge clk) disable iff (rst)
    (use_bak != $past(use_bak)) |-> $past(hold_req));

  // R7
  lock_only_primary_chk: assert property (@(posedge clk) disable iff (rst)
    !lock_n |-> (!use_bak && !hold_req));

  // R8
  acq_before_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_n) |-> $past(acq_done));

  // R9
  lock_window_chk: assert property (@(posedge clk) disable iff (rst)
    !lock_n |-> $past(pri_in_win));

  // R12
  no_target_chk: assert property (@(posedge clk) disable iff (rst)
    (state == FO_PRI && !bak_valid) |=> !hold_req);
endmodule

// File: rtl/refmon_failover.sv
`timescale 1ns/1ps
module refmon_failover
  import refmon_pkg::*;
#(
  parameter int GATE_CYC     = 2048,
  parameter int BAND0_NOM    = 16,
  parameter int BAND_TOL_DIV = 4,
  parameter int LOCK_TOL_DIV = 16,
  parameter int HOLD_CYC     = 16,
  parameter int ACQ_CYC      = 8192
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pri_clk,
  input  logic       bak_clk,
  input  logic [3:0] band_sel,
  output logic       use_bak,
  output logic [5:0] fb_div,
  output logic       hold_req,
  output logic       lock_n
);
  localparam int GATE_W = $clog2(GATE_CYC);
  localparam int CNT_W  = $clog2(GATE_CYC + 1);
  localparam int NCH    = 2;

  logic [GATE_W-1:0] gate_cnt;
  logic              gate_end;
  logic [NCH-1:0]    ref_in;
  logic [CNT_W-1:0]  meas_a [NCH];
  logic [NCH-1:0]    done_a;
  logic [NCH-1:0]    valid_a;
  band_t             band_a [NCH];
  band_req_t         req;
  logic              pri_in_win;

  assign ref_in     = {bak_clk, pri_clk};
  assign gate_end   = gate_cnt == GATE_W'(GATE_CYC - 1);
  assign req        = decode_band_sel(band_sel);
  assign pri_in_win = in_lock_window(int'(meas_a[0]), band_a[0], BAND0_NOM, LOCK_TOL_DIV);

  always_ff @(posedge clk) begin
    if (rst) gate_cnt <= '0;
    else if (gate_end) gate_cnt <= '0;
    else gate_cnt <= gate_cnt + GATE_W'(1);
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    ref_edge_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk       (clk),
      .rst       (rst),
      .ref_clk   (ref_in[ch]),
      .gate_end  (gate_end),
      .meas      (meas_a[ch]),
      .meas_done (done_a[ch])
    );
    ref_qualifier #(
      .CNT_W        (CNT_W),
      .BAND0_NOM    (BAND0_NOM),
      .BAND_TOL_DIV (BAND_TOL_DIV)
    ) i_qual (
      .clk       (clk),
      .rst       (rst),
      .meas      (meas_a[ch]),
      .meas_done (done_a[ch]),
      .manual    (req.manual),
      .man_band  (req.band),
      .valid     (valid_a[ch]),
      .band      (band_a[ch])
    );
  end

  failover_ctrl #(.HOLD_CYC(HOLD_CYC), .ACQ_CYC(ACQ_CYC)) i_fo (
    .clk        (clk),
    .rst        (rst),
    .pri_valid  (valid_a[0]),
    .bak_valid  (valid_a[1]),
    .pri_band   (band_a[0]),
    .bak_band   (band_a[1]),
    .pri_in_win (pri_in_win),
    .use_bak    (use_bak),
    .hold_req   (hold_req),
    .lock_n     (lock_n),
    .fb_div     (fb_div)
  );
endmodule

// File: tb/test_refmon_failover.sv
`timescale 1ns/1ps
module test_refmon_failover;
  localparam int GATE = 2048;
  localparam int HOLD = 16;
  localparam int ACQ  = 8192;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pri_clk = 1'b0;
  logic       bak_clk = 1'b0;
  logic [3:0] band_sel = 4'b0101;
  logic       use_bak;
  logic [5:0] fb_div;
  logic       hold_req;
  logic       lock_n;

  real pri_half = 0.0;
  real bak_half = 0.0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // expected item: {mask[3:0], use_bak, hold_req, lock_n, fb_div[5:0]}
  logic [12:0] exp_q[$];
  string       tag_q[$];

  refmon_failover i_refmon_failover (
    .clk      (clk),
    .rst      (rst),
    .pri_clk  (pri_clk),
    .bak_clk  (bak_clk),
    .band_sel (band_sel),
    .use_bak  (use_bak),
    .fb_div   (fb_div),
    .hold_req (hold_req),
    .lock_n   (lock_n)
  );

  always #2.5 clk = ~clk;

  always begin
    if (pri_half == 0.0) begin pri_clk = 1'b0; #7; end
    else begin #(pri_half) pri_clk = ~pri_clk; end
  end

  always begin
    if (bak_half == 0.0) begin bak_clk = 1'b0; #9; end
    else begin #(bak_half) bak_clk = ~bak_clk; end
  end

  task automatic cmp(input string tg, input string fld, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tg, fld, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    logic [12:0] it;
    string       tg;
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        it = exp_q.pop_front();
        tg = tag_q.pop_front();
        if (it[12]) cmp(tg, "use_bak",  int'(use_bak),  int'(it[8]));
        if (it[11]) cmp(tg, "hold_req", int'(hold_req), int'(it[7]));
        if (it[10]) cmp(tg, "lock_n",   int'(lock_n),   int'(it[6]));
        if (it[9])  cmp(tg, "fb_div",   int'(fb_div),   int'(it[5:0]));
      end
    end
  end

  // driver side: push an expectation and wait for the monitor to consume it
  task automatic expect_out(input string tg, input logic [3:0] m, input logic ub,
                            input logic hd, input logic ln, input logic [5:0] fb);
    exp_q.push_back({m, ub, hd, ln, fb});
    tag_q.push_back(tg);
    while (exp_q.size() != 0) @(posedge clk);
  endtask

  task automatic wait_gates(input int n);
    repeat (n * GATE) @(posedge clk);
  endtask

  task automatic wait_use_bak(input logic val, input int maxcyc);
    for (int i = 0; i < maxcyc; i++) begin
      @(negedge clk);
      if (use_bak == val) break;
    end
  endtask

  task automatic wait_hold(input int maxcyc);
    for (int i = 0; i < maxcyc; i++) begin
      @(negedge clk);
      if (hold_req) break;
    end
  endtask

  task automatic summary;
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bak_half = 20.0;              // backup: 256 edges per gate, band 4
    repeat (8) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(posedge clk);
    // R1: reset state
    expect_out("R1 reset", 4'b1111, 1'b0, 1'b0, 1'b1, 6'd32);

    // R3: one in-band backup measurement is not enough
    repeat (2200) @(posedge clk);
    expect_out("R3 single measurement", 4'b1100, 1'b0, 1'b0, 1'b0, 6'd0);

    // R5/R4/R7: second measurement validates backup, switch, ratio 2, no lock
    repeat (2300) @(posedge clk);
    expect_out("R5 R4 R7 on backup", 4'b1111, 1'b1, 1'b0, 1'b1, 6'd2);

    // R6: primary appears in band 2 (64 edges per gate)
    pri_half = 80.0;
    wait_use_bak(1'b0, 5 * GATE);
    expect_out("R6 back to primary", 4'b1111, 1'b0, 1'b0, 1'b1, 6'd8);

    // R8: acquisition period
    repeat (ACQ - 1200) @(posedge clk);
    expect_out("R8 before acquisition", 4'b0010, 1'b0, 1'b0, 1'b1, 6'd0);
    repeat (2500) @(posedge clk);
    expect_out("R8 R7 locked", 4'b1111, 1'b0, 1'b0, 1'b0, 6'd8);

    // R9: in band but outside lock window (72 edges)
    pri_half = 71.111;
    wait_gates(3);
    expect_out("R9 drift unlocks", 4'b1010, 1'b0, 1'b0, 1'b1, 6'd0);
    pri_half = 80.0;
    wait_gates(3);
    expect_out("R9 window regained", 4'b1010, 1'b0, 1'b0, 1'b0, 6'd0);

    // R2: count between bands (88 edges) invalidates primary
    pri_half = 58.182;
    wait_gates(3);
    expect_out("R2 out of all bands", 4'b1011, 1'b1, 1'b0, 1'b1, 6'd2);
    pri_half = 80.0;
    wait_use_bak(1'b0, 5 * GATE);
    expect_out("R6 R4 return band2", 4'b1001, 1'b0, 1'b0, 1'b0, 6'd8);

    // R5: stopped primary, hold precedes the switch
    pri_half = 0.0;
    wait_hold(3 * GATE);
    expect_out("R5 hold before switch", 4'b1100, 1'b0, 1'b1, 1'b0, 6'd0);
    repeat (8) @(posedge clk);
    expect_out("R5 hold still held", 4'b1100, 1'b0, 1'b1, 1'b0, 6'd0);
    repeat (16) @(posedge clk);
    expect_out("R5 switched", 4'b1111, 1'b1, 1'b0, 1'b1, 6'd2);

    // R4: lowest and highest bands
    pri_half = 320.0;
    wait_gates(6);
    expect_out("R4 band0 ratio", 4'b1001, 1'b0, 1'b0, 1'b0, 6'd32);
    pri_half = 10.0;
    wait_gates(6);
    expect_out("R4 band5 ratio", 4'b1001, 1'b0, 1'b0, 1'b0, 6'd1);

    // R10: manual band 2 = (mid,high) = 4'b0110
    pri_half = 80.0;
    band_sel = 4'b0110;
    wait_gates(5);
    expect_out("R10 manual band2", 4'b1001, 1'b0, 1'b0, 1'b0, 6'd8);

    // R11/R12: backup in band 4 is rejected; primary stopped -> stay, no hold
    pri_half = 0.0;
    wait_gates(3);
    expect_out("R11 R12 no valid target", 4'b1101, 1'b0, 1'b0, 1'b0, 6'd8);

    // R10: manual band 4 = (low,high) = 4'b0010 admits the backup
    band_sel = 4'b0010;
    wait_gates(4);
    expect_out("R10 manual band4", 4'b1001, 1'b1, 1'b0, 1'b0, 6'd2);

    // R10: reserved (high,mid) = 4'b1001 acts as automatic
    pri_half = 80.0;
    band_sel = 4'b1001;
    wait_gates(5);
    expect_out("R10 reserved is auto", 4'b1001, 1'b0, 1'b0, 1'b0, 6'd8);

    summary();
    $finish;
  end
endmodule